// File: doc/BRIEF.md
# Block-access configuration target on a two-wire serial bus

This block is a two-wire serial bus target that holds six 8-bit control registers. Bits of the first two registers gate six differential clock output pairs. The block runs on a system clock and oversamples the bus clock and data lines. It recognises START and STOP conditions and answers two fixed address bytes: one for writing and one for reading.

There is no register pointer. Every access is a block that begins at register 0.

- **Write.** The host first sends two leading bytes, a command code and then a count. The block acknowledges both and ignores their values. Each data byte that follows lands in the next register, in ascending order.
- **Read.** The block first returns a byte count. It then streams out registers 0 through 5.
- **Bus drive.** The data line is pulled low through an open-drain drive signal. The pull-down changes only while the bus clock is low.

Top module: `cfg_i2c_target`

## Requirements
- R1: The address byte 0xD2 (bits 7:1 = 0x69, bit 0 = 0) is acknowledged as a write and 0xD3 (bit 0 = 1) as a read. Any other address byte is not acknowledged, and the block does not pull SDA until the next START.
- R2: In a write, the first two bytes after the address (command and count) are acknowledged and not stored. The first data byte goes to register 0.
- R3: Data bytes after the count byte are stored into registers 0, 1, … 5 in that order and each is acknowledged. Bytes beyond register 5 are acknowledged and discarded.
- R4: A write may end with STOP after any complete byte. Registers not reached keep their previous values.
- R5: A read sends the count value 6 first, then registers 0 to 5 in order. Bytes are sent most significant bit first.
- R6: A NACK from the host after a read byte releases SDA and returns the block to idle. Further SCL pulses then read all ones until the next START.
- R7: After reset, registers 0 to 4 hold 0xFF, register 5 holds 0x06, all six enables are 1, and SDA is released.
- R8: The enable output maps as follows, with 1 meaning enabled:
  - pair_en_o[0] is register 0 bit 7
  - [1] is register 0 bit 6
  - [2] is register 0 bit 3
  - [3] is register 1 bit 6
  - [4] is register 0 bit 0
  - [5] is register 0 bit 2
- R9: A START or STOP in the middle of a byte abandons the transfer without changing any register.
- R10: The SDA pull-down changes only while SCL is low. Acknowledges are driven low across the ninth SCL pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired-AND value) |
| sda_pull_o | output | 1 | 1 pulls the data line low (open-drain drive) |
| pair_en_o | output | 6 | Enable per differential output pair, see R8 |

## Verification
Both bus lines pass through a two-stage synchroniser followed by one edge-detect stage. A pull-down or a register update therefore appears three system clocks after the SCL edge that causes it. Acknowledges and read bits take effect from the SCL falling edge. Stored data takes effect from the falling edge that ends a data byte's eighth bit.

The bench holds every bus phase for ten system clocks. It reads SDA and the enables only mid-phase, well past that three-clock latency and before the next edge. A separate monitor compares successive pull-down values against SCL to check that the drive never moves while SCL is high.

// File: rtl/cfg_i2c_target.sv
module cfg_i2c_target #(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         NREG     = 6,
  parameter logic [7:0] LAST_RST = 8'h06
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  output logic [5:0] pair_en_o
);

  localparam int         PW      = $clog2(NREG + 3);
  localparam logic [PW-1:0] POS_MAX = PW'(NREG + 2);
  localparam logic [7:0] CNT_BYTE = 8'(NREG);

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_ACK, S_WDAT, S_RDAT, S_RACK, S_RNXT, S_IGN
  } st_t;

  st_t                  state;
  logic [2:0]           scl_sy, sda_sy;
  logic [3:0]           bitcnt;
  logic [7:0]           sh;
  logic [PW-1:0]        pos;
  logic                 rd;
  logic [NREG-1:0][7:0] regs;
  logic [7:0]           tx_next;

  wire scl_s = scl_sy[1];
  wire scl_q = scl_sy[2];
  wire sda_s = sda_sy[1];
  wire sda_q = sda_sy[2];

  wire rise    = scl_s & ~scl_q;
  wire fall    = ~scl_s & scl_q;
  wire start_c = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c  = scl_s & scl_q & ~sda_q & sda_s;

  always_comb begin
    tx_next = 8'hFF;
    if (pos == '0) tx_next = CNT_BYTE;
    for (int i = 0; i < NREG; i++)
      if (pos == PW'(i + 1)) tx_next = regs[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sy     <= 3'b111;
      sda_sy     <= 3'b111;
      state      <= S_IDLE;
      sda_pull_o <= 1'b0;
      bitcnt     <= '0;
      sh         <= '0;
      pos        <= '0;
      rd         <= 1'b0;
      for (int i = 0; i < NREG; i++)
        regs[i] <= (i == NREG - 1) ? LAST_RST : 8'hFF;
    end else begin
      scl_sy <= {scl_sy[1:0], scl_i};
      sda_sy <= {sda_sy[1:0], sda_i};
      if (start_c) begin
        state      <= S_ADDR;
        bitcnt     <= '0;
        pos        <= '0;
        sda_pull_o <= 1'b0;
      end else if (stop_c) begin
        state      <= S_IDLE;
        sda_pull_o <= 1'b0;
      end else begin
        case (state)
          S_ADDR, S_WDAT: begin
            if (rise && bitcnt < 4'd8) begin
              sh     <= {sh[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (fall && bitcnt == 4'd8) begin
              bitcnt <= '0;
              if (state == S_ADDR) begin
                if (sh[7:1] == DEV_ADDR) begin
                  rd         <= sh[0];
                  state      <= S_ACK;
                  sda_pull_o <= 1'b1;
                end else begin
                  state <= S_IGN;
                end
              end else begin
                for (int i = 0; i < NREG; i++)
                  if (pos == PW'(i + 2)) regs[i] <= sh;
                if (pos != POS_MAX) pos <= pos + 1'b1;
                state      <= S_ACK;
                sda_pull_o <= 1'b1;
              end
            end
          end
          S_ACK: begin
            if (fall) begin
              bitcnt <= '0;
              if (rd) begin
                state      <= S_RDAT;
                sh         <= tx_next;
                sda_pull_o <= ~tx_next[7];
              end else begin
                state      <= S_WDAT;
                sda_pull_o <= 1'b0;
              end
            end
          end
          S_RDAT: begin
            if (rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (fall) begin
              if (bitcnt == 4'd8) begin
                sda_pull_o <= 1'b0;
                state      <= S_RACK;
                if (pos != POS_MAX) pos <= pos + 1'b1;
              end else begin
                sh         <= {sh[6:0], 1'b0};
                sda_pull_o <= ~sh[6];
              end
            end
          end
          S_RACK: begin
            if (rise) state <= sda_s ? S_IDLE : S_RNXT;
          end
          S_RNXT: begin
            if (fall) begin
              sh         <= tx_next;
              sda_pull_o <= ~tx_next[7];
              bitcnt     <= '0;
              state      <= S_RDAT;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign pair_en_o = {regs[0][2], regs[0][0], regs[1][6],
                      regs[0][3], regs[0][6], regs[0][7]};

endmodule

// File: rtl/cfg_i2c_target_chk.sv
module cfg_i2c_target_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_i,
  input logic        sda_pull_o,
  input logic [2:0]  state,
  input logic [47:0] regs_flat
);

  localparam logic [2:0] ST_IDLE = 3'd0;
  localparam logic [2:0] ST_WDAT = 3'd3;
  localparam logic [2:0] ST_IGN  = 3'd7;

  assert_pull_moves_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull_o != $past(sda_pull_o)) |-> !scl_i);

  assert_ignore_is_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IGN) |-> !sda_pull_o);

  assert_idle_releases_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_pull_o);

  assert_regs_only_from_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (regs_flat != $past(regs_flat)) |-> ($past(state) == ST_WDAT));

endmodule

bind cfg_i2c_target cfg_i2c_target_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_i      (scl_i),
  .sda_pull_o (sda_pull_o),
  .state      (state),
  .regs_flat  (regs)
);

// File: tb/cfg_i2c_target_tb_top.sv
module cfg_i2c_target_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_scl = 1'b1;
  logic       host_sda = 1'b1;
  logic       sda_pull;
  logic [5:0] en;
  wire        sda_line = host_sda & ~sda_pull;

  always #4 clk = ~clk;

  cfg_i2c_target dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(host_scl), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .pair_en_o(en)
  );

  localparam int Q = 10;
  localparam logic [67:0] VEC [4] = '{
    {4'd6, 64'h0000_0000_0000_0000},
    {4'd6, 64'h8100_1122_3344_0000},
    {4'd2, 64'h4C40_0000_0000_0000},
    {4'd0, 64'hDEAD_BEEF_0000_0000}
  };

  int total = 0, bad = 0, r10_viol = 0;
  logic [7:0] mdl [6];
  logic prev_pull = 1'b0, prev_scl = 1'b1;
  bit done = 1'b0;

  always @(posedge clk) begin
    if (rst_n && sda_pull != prev_pull && host_scl && prev_scl) r10_viol++;
    prev_pull <= sda_pull;
    prev_scl  <= host_scl;
  end

  function automatic logic [5:0] exp_en();
    return {mdl[0][2], mdl[0][0], mdl[1][6], mdl[0][3], mdl[0][6], mdl[0][7]};
  endfunction

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic host_start();
    host_sda = 1'b1; wq(); host_scl = 1'b1; wq();
    host_sda = 1'b0; wq(); host_scl = 1'b0; wq();
  endtask

  task automatic host_stop();
    host_sda = 1'b0; wq(); host_scl = 1'b1; wq(); host_sda = 1'b1; wq();
  endtask

  task automatic wbit(input logic b);
    host_sda = b; wq(); host_scl = 1'b1; wq(); wq(); host_scl = 1'b0; wq();
  endtask

  task automatic rbit(output logic b);
    host_sda = 1'b1; wq(); host_scl = 1'b1; wq(); b = sda_line; wq(); host_scl = 1'b0; wq();
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(a);
    ack = ~a;
  endtask

  task automatic rbyte(output logic [7:0] d, input logic nack);
    logic b;
    for (int i = 7; i >= 0; i--) begin rbit(b); d[i] = b; end
    wbit(nack);
  endtask

  task automatic write_seq(input int n, input logic [63:0] data);
    logic ack;
    host_start();
    wbyte(8'hD2, ack); chk("R1", "write address ack", 32'(ack), 32'd1);
    wbyte(8'h5A, ack); chk("R2", "command byte ack", 32'(ack), 32'd1);
    wbyte(8'h07, ack); chk("R2", "count byte ack", 32'(ack), 32'd1);
    for (int k = 0; k < n; k++) begin
      wbyte(data[63-8*k -: 8], ack);
      chk("R3", $sformatf("data byte %0d ack", k), 32'(ack), 32'd1);
      if (k < 6) mdl[k] = data[63-8*k -: 8];
    end
    host_stop();
  endtask

  task automatic read_check(input string req);
    logic ack;
    logic [7:0] d;
    host_start();
    wbyte(8'hD3, ack); chk("R1", "read address ack", 32'(ack), 32'd1);
    rbyte(d, 1'b0);    chk("R5", "count byte", 32'(d), 32'd6);
    for (int k = 0; k < 6; k++) begin
      rbyte(d, k == 5);
      chk(req, $sformatf("readback reg %0d", k), 32'(d), 32'(mdl[k]));
    end
    host_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic ack, b;
    logic [7:0] d;
    for (int k = 0; k < 5; k++) mdl[k] = 8'hFF;
    mdl[5] = 8'h06;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    wq();

    // R7 reset state
    chk("R7", "enables after reset", 32'(en), 32'h3F);
    chk("R7", "SDA released after reset", 32'(sda_pull), 32'd0);
    read_check("R7");

    // table of block writes, R4 partial writes, R8 enable mapping
    for (int v = 0; v < 4; v++) begin
      write_seq(int'(VEC[v][67:64]), VEC[v][63:0]);
      chk("R8", $sformatf("enables after vector %0d", v), 32'(en), 32'(exp_en()));
      read_check(v >= 2 ? "R4" : "R5");
    end

    // R3 overflow beyond register 5
    write_seq(8, 64'h0102_0304_0506_0708);
    chk("R8", "enables after overflow write", 32'(en), 32'(exp_en()));
    read_check("R3");

    // R9 STOP inside a data byte
    host_start();
    wbyte(8'hD2, ack); wbyte(8'h5A, ack); wbyte(8'h07, ack);
    for (int i = 0; i < 4; i++) wbit(1'b0);
    host_stop();
    chk("R9", "enables after mid-byte STOP", 32'(en), 32'(exp_en()));
    read_check("R9");

    // R9 START inside a data byte (first data byte complete)
    host_start();
    wbyte(8'hD2, ack); wbyte(8'h5A, ack); wbyte(8'h07, ack);
    wbyte(8'hAA, ack); mdl[0] = 8'hAA;
    for (int i = 0; i < 5; i++) wbit(i[0]);
    host_start();
    host_stop();
    read_check("R9");

    // R1 foreign address ignored until next START
    host_start();
    wbyte(8'hA0, ack); chk("R1", "foreign address nack", 32'(ack), 32'd0);
    wbyte(8'hD2, ack); chk("R1", "still ignored without START", 32'(ack), 32'd0);
    host_stop();
    read_check("R1");

    // R6 early NACK
    host_start();
    wbyte(8'hD3, ack);
    rbyte(d, 1'b1); chk("R6", "count before NACK", 32'(d), 32'd6);
    for (int i = 7; i >= 0; i--) begin rbit(b); d[i] = b; end
    chk("R6", "bus reads ones after NACK", 32'(d), 32'hFF);
    chk("R6", "SDA released after NACK", 32'(sda_pull), 32'd0);
    wbit(1'b1);
    host_stop();
    read_check("R6");

    // R10 drive changes only with SCL low
    chk("R10", "pull-down changes while SCL high", 32'(r10_viol), 32'd0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule